// File: doc/BRIEF.md
# Cycle Timestamp Counter with Match Interrupts

This block keeps a free-running cycle count and raises interrupts at chosen points in time. A counter advances by one on every clock from a reset value of zero. Software can read it, but no register access can change it. Each compare slot holds a value. When the count equals that value, the slot's interrupt line goes high and stays high.

Software uses a small word-addressed register port. It arms a slot by writing a target count. It acknowledges an interrupt by writing that same slot again. Any write to the slot clears the line, whatever value is written. The port is synchronous, with no handshake. A write takes effect at the clock edge where `reg_wr` is high. Read data follows `reg_addr` combinationally and shows the current register contents.

Top module: `cyc_timer`

## Requirements
- R1: After reset the count (byte offset 0x00) reads zero, and it then rises by exactly one on every clock edge, wrapping to zero after all ones.
- R2: A write to offset 0x00 has no effect, and the count keeps its one-per-clock sequence.
- R3: Compare slot 0 sits at offset 0x08 and slot 1 at offset 0x10. Each slot resets to all ones and reads back the last value written to it.
- R4: When the count equals a slot's value during a cycle, that slot's `irq` bit is high from the next clock edge on (`irq[0]` belongs to slot 0, `irq[1]` to slot 1).
- R5: An `irq` bit that is set stays high after the count has moved past the match, until its slot is written.
- R6: A write to a slot drives that slot's `irq` bit low at the same edge, whatever data is written, unless R7 applies.
- R7: If the data written to a slot equals the count in the cycle of the write, the set wins and the `irq` bit is high after that edge.
- R8: Offsets that are not multiples of 8, or that lie at 0x18 and above, read as zero, and writes to them change no register and no `irq` bit.
- R9: Writing one slot leaves the other slot's value and `irq` bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_addr | input | 5 | Byte offset of the register accessed |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr`, combinational |
| irq | output | 2 | Sticky match interrupts, one bit per compare slot |

## Verification
Read data depends only on the address and on registered state, so it is valid in the same cycle as the address. The count in that cycle equals the number of clock edges since reset was released. A match, or a write to a slot, shows up on `irq` one edge after the cycle in which it happens. A write to a slot also shows in the read-back one edge later. The bench drives inputs just after each rising edge. It advances a behavioural reference at the rising edge, using the same inputs the design samples. It compares every output at the falling edge, so each expected value is checked in the cycle it falls due.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;
  localparam int DEF_CNT_W   = 64;
  localparam int DEF_NUM_CMP = 2;
  localparam int REG_STRIDE  = 8;
  localparam int REG_SHIFT   = $clog2(REG_STRIDE);

  // Next state of a sticky interrupt: a match sets it, a slot write clears it,
  // and the set wins when both occur in the same cycle.
  function automatic logic irq_next(input logic cur, input logic hit, input logic clr);
    return hit | (cur & ~clr);
  endfunction
endpackage

// File: rtl/cyc_counter.sv
module cyc_counter #(
  parameter int W = cyc_timer_pkg::DEF_CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] count
);
  function automatic logic [W-1:0] step(input logic [W-1:0] v);
    return v + {{(W-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= step(count);
  end
endmodule

// File: rtl/cyc_reg_decode.sv
module cyc_reg_decode #(
  parameter int NUM_CMP = cyc_timer_pkg::DEF_NUM_CMP,
  parameter int ADDR_W  = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic [NUM_CMP:0]  sel,
  output logic [NUM_CMP-1:0] cmp_wr
);
  import cyc_timer_pkg::*;
  localparam int IDX_W = ADDR_W - REG_SHIFT;

  logic aligned;
  assign aligned = (addr[REG_SHIFT-1:0] == '0);

  for (genvar k = 0; k <= NUM_CMP; k++) begin : g_sel
    assign sel[k] = aligned && (addr[ADDR_W-1:REG_SHIFT] == IDX_W'(k));
  end

  assign cmp_wr = sel[NUM_CMP:1] & {NUM_CMP{wr}};
endmodule

// File: rtl/cyc_cmp_unit.sv
module cyc_cmp_unit #(
  parameter int W = cyc_timer_pkg::DEF_CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] count,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cmp_q,
  output logic         hit,
  output logic         irq_q
);
  import cyc_timer_pkg::*;

  logic [W-1:0] cmp_eff;
  assign cmp_eff = wr ? wdata : cmp_q;
  assign hit     = (count == cmp_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '1;
      irq_q <= 1'b0;
    end else begin
      cmp_q <= cmp_eff;
      irq_q <= irq_next(irq_q, hit, wr);
    end
  end
endmodule

// File: rtl/cyc_timer.sv
module cyc_timer #(
  parameter int CNT_W   = cyc_timer_pkg::DEF_CNT_W,
  parameter int NUM_CMP = cyc_timer_pkg::DEF_NUM_CMP,
  parameter int ADDR_W  = $clog2((NUM_CMP + 1) * cyc_timer_pkg::REG_STRIDE)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [CNT_W-1:0]   reg_wdata,
  output logic [CNT_W-1:0]   reg_rdata,
  output logic [NUM_CMP-1:0] irq
);
  logic [CNT_W-1:0]              cnt_val;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_val;
  logic [NUM_CMP-1:0]            match_vec;
  logic [NUM_CMP-1:0]            cmp_wr;
  logic [NUM_CMP:0]              rd_sel;

  cyc_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .count (cnt_val)
  );

  cyc_reg_decode #(.NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)) u_dec (
    .addr   (reg_addr),
    .wr     (reg_wr),
    .sel    (rd_sel),
    .cmp_wr (cmp_wr)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    cyc_cmp_unit #(.W(CNT_W)) u_unit (
      .clk   (clk),
      .rst_n (rst_n),
      .count (cnt_val),
      .wr    (cmp_wr[i]),
      .wdata (reg_wdata),
      .cmp_q (cmp_val[i]),
      .hit   (match_vec[i]),
      .irq_q (irq[i])
    );
  end

  always_comb begin
    reg_rdata = rd_sel[0] ? cnt_val : '0;
    for (int i = 0; i < NUM_CMP; i++) begin
      if (rd_sel[i+1]) reg_rdata = cmp_val[i];
    end
  end
endmodule

// File: rtl/cyc_timer_chk.sv
module cyc_timer_chk #(
  parameter int CNT_W   = 64,
  parameter int NUM_CMP = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [CNT_W-1:0]              cnt_val,
  input logic [NUM_CMP-1:0][CNT_W-1:0] cmp_val,
  input logic [NUM_CMP-1:0]            match_vec,
  input logic [NUM_CMP-1:0]            cmp_wr,
  input logic [NUM_CMP-1:0]            irq
);
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> cnt_val == $past(cnt_val) + 1'b1);

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_p
    p_irq_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      match_vec[i] |=> irq[i]);
    p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> $past(match_vec[i]));
    p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[i] && !cmp_wr[i]) |=> irq[i]);
    p_irq_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_wr[i] && !match_vec[i]) |=> !irq[i]);
    p_cmp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_wr[i] |=> $stable(cmp_val[i]));
  end
endmodule

bind cyc_timer cyc_timer_chk #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_val   (cnt_val),
  .cmp_val   (cmp_val),
  .match_vec (match_vec),
  .cmp_wr    (cmp_wr),
  .irq       (irq)
);

// File: tb/sim_cyc_timer.sv
module sim_cyc_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference
  longint unsigned m_cnt;
  longint unsigned m_cmp [2];
  bit              m_irq [2];

  cyc_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint unsigned act,
                     input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint unsigned m_read(input logic [4:0] a);
    if (a == 5'h00) return m_cnt;
    if (a == 5'h08) return m_cmp[0];
    if (a == 5'h10) return m_cmp[1];
    return 64'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0;
      m_cmp[0] = '1; m_cmp[1] = '1;
      m_irq[0] = 0;  m_irq[1] = 0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        bit wi;
        longint unsigned eff;
        wi  = reg_wr && (reg_addr == 5'(8 * (i + 1)));
        eff = wi ? reg_wdata : m_cmp[i];
        m_irq[i] = (m_cnt == eff) || (m_irq[i] && !wi);
        m_cmp[i] = eff;
      end
      m_cnt = m_cnt + 1;
    end
  end

  // per-clock comparison at the falling edge
  always @(negedge clk) begin
    string tag;
    tag = (reg_addr == 5'h00) ? "R1" : ((reg_addr == 5'h08 || reg_addr == 5'h10) ? "R3" : "R8");
    chk(reg_rdata == m_read(reg_addr), tag, reg_rdata, m_read(reg_addr));
    chk(irq[0] == m_irq[0], "R4", irq[0], m_irq[0]);
    chk(irq[1] == m_irq[1], "R4", irq[1], m_irq[1]);
  end

  task automatic wr_reg(input logic [4:0] a, input longint unsigned d, input bit rel);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a;
    reg_wdata = rel ? m_cnt + d : d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd_at(input logic [4:0] a);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  initial begin
    #200000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk(reg_rdata == 64'h0, "R1", reg_rdata, 0);
    chk(irq == 2'b00, "R4", irq, 0);
    reg_addr = 5'h08; #1;
    chk(reg_rdata == '1, "R3", reg_rdata, '1);
    reg_addr = 5'h10; #1;
    chk(reg_rdata == '1, "R3", reg_rdata, '1);
    reg_addr = 5'h00;
    @(negedge clk); rst_n = 1'b1;
    idle(3);

    // R1 count steps once per clock
    rd_at(5'h00);
    chk(reg_rdata == m_cnt, "R1", reg_rdata, m_cnt);

    // R4 arm both slots, R5 stickiness after passing
    wr_reg(5'h08, 20, 1);
    wr_reg(5'h10, 30, 1);
    rd_at(5'h08);
    chk(reg_rdata == m_cmp[0], "R3", reg_rdata, m_cmp[0]);
    idle(45);
    @(negedge clk);
    chk(irq == 2'b11, "R5", irq, 3);

    // R6 arbitrary write clears slot 0 only, R9 slot 1 untouched
    wr_reg(5'h08, 64'hDEAD_0000_BEEF, 0);
    @(negedge clk);
    chk(irq[0] == 1'b0, "R6", irq[0], 0);
    chk(irq[1] == 1'b1, "R9", irq[1], 1);
    rd_at(5'h10);
    chk(reg_rdata == m_cmp[1], "R9", reg_rdata, m_cmp[1]);

    // R7 write equal to current count: set wins
    wr_reg(5'h10, 64'h1234_5678, 0);
    @(negedge clk);
    chk(irq[1] == 1'b0, "R6", irq[1], 0);
    wr_reg(5'h10, 0, 1);
    @(negedge clk);
    chk(irq[1] == 1'b1, "R7", irq[1], 1);

    // R2 writes to the count are dropped
    wr_reg(5'h00, 64'h5555_0000_0000, 0);
    rd_at(5'h00);
    chk(reg_rdata == m_cnt && reg_rdata < 64'h1000, "R2", reg_rdata, m_cnt);

    // R8 unmapped and misaligned offsets
    wr_reg(5'h18, 2, 1);
    wr_reg(5'h09, 2, 1);
    rd_at(5'h18);
    chk(reg_rdata == 64'h0, "R8", reg_rdata, 0);
    rd_at(5'h09);
    chk(reg_rdata == 64'h0, "R8", reg_rdata, 0);
    rd_at(5'h08);
    chk(reg_rdata == 64'hDEAD_0000_BEEF, "R8", reg_rdata, 64'hDEAD_0000_BEEF);
    idle(4);
    @(negedge clk);
    chk(irq[0] == 1'b0, "R8", irq[0], 0);

    // R4 exact timing of a short arm
    wr_reg(5'h08, 5, 1);
    idle(3);
    @(negedge clk);
    chk(irq[0] == 1'b0, "R4", irq[0], 0);
    idle(3);
    @(negedge clk);
    chk(irq[0] == 1'b1, "R4", irq[0], 1);
    idle(5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule